// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a paged memory system. A lookup presents a 30-bit virtual page number (bits 42:13 of a 43-bit virtual address) together with the 13-bit page offset. Every valid entry is compared with the key in the same cycle. A hit returns the 21-bit physical page number, the permission flags, the global marker and the 34-bit physical address. A miss is reported so that the page-table walker can read the tables and then write the translation through the fill port.

Each entry is marked either global, meaning it belongs to the operating system, or per-process. A context-switch flush removes every per-process translation in one clock and leaves the global ones in place. As a result, kernel translations survive a process switch. The depth is a parameter: 12 suits an instruction-side buffer and 32 suits a data-side one. Because the buffer is fully associative, there are no conflict misses and no index hashing.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid: every lookup misses, and lk_hit_o is 0.
- R2: Lookup is combinational. Hit, page number, flags and global bit follow lk_vpn_i in the same cycle. A fill is not visible in its own cycle and becomes visible after the next rising clock edge.
- R3: lk_miss_o is 1 exactly when lk_valid_i is 1 and no valid entry matches. lk_hit_o requires lk_valid_i. Without a hit, lk_ppn_o, lk_flags_o, lk_global_o and lk_paddr_o are all zero.
- R4: At most one entry ever matches a key. Filling a page number that is already present overwrites that entry in place: the new page number is returned, and no other entry is consumed.
- R5: A pulse on flush_proc_i invalidates every entry whose global bit is 0 at the next edge. Entries with the global bit set keep their translations.
- R6: When a fill and a flush arrive in the same cycle, the flush is applied first and the fill is written after it. The filled translation is valid afterwards even if it is per-process.
- R7: A fill of a new page number goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry named by a round-robin pointer. The pointer is 0 after reset, advances by one each time it is used, and wraps after the last entry.
- R8: On a hit, lk_paddr_o is {lk_ppn_o, lk_off_i}, 34 bits wide.
- R9: On a hit, lk_flags_o returns the 4 flag bits stored by the fill: bit 0 read, bit 1 write, bit 2 execute, bit 3 uncached. lk_global_o returns the stored global bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 30 | Lookup virtual page number |
| lk_off_i | input | 13 | Page offset of the lookup address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss; a page-table walk is needed |
| lk_ppn_o | output | 21 | Physical page number on hit |
| lk_flags_o | output | 4 | Permission flags on hit |
| lk_global_o | output | 1 | Hit entry is global |
| lk_paddr_o | output | 34 | Physical address on hit |
| fill_en_i | input | 1 | Write a translation |
| fill_vpn_i | input | 30 | Virtual page number to write |
| fill_ppn_i | input | 21 | Physical page number to write |
| fill_flags_i | input | 4 | Flags to write |
| fill_global_i | input | 1 | 1 marks the translation as global |
| flush_proc_i | input | 1 | Context-switch flush of per-process entries |

## Verification
Lookup results are due in the same cycle as the key, so the bench drives the key on a falling edge and samples one nanosecond later, before the next rising edge. A fill or flush is due one rising edge after it is driven. The bench holds the strobe for exactly one cycle, drops it at the next falling edge, and only then samples lookups. That places every observation after the register update and never on it. Replacement order is observed through which translation disappears when a full buffer takes new page numbers.

// File: rtl/xlat_tlb_pkg.sv
`timescale 1ns/1ps
package xlat_tlb_pkg;
  localparam int unsigned VPN_W  = 30;
  localparam int unsigned PPN_W  = 21;
  localparam int unsigned OFF_W  = 13;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned PA_W   = PPN_W + OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
    logic              glb;
  } xl_ent_t;
endpackage

// File: rtl/xlat_tlb_cam.sv
`timescale 1ns/1ps
module xlat_tlb_cam
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  xl_ent_t [ENTRIES-1:0] ents_i,
  input  logic    [ENTRIES-1:0] valid_i,
  input  logic    [VPN_W-1:0]   key_i,
  output logic    [ENTRIES-1:0] hit_vec_o,
  output logic                  hit_o,
  output logic    [IDX_W-1:0]   idx_o,
  output xl_ent_t               ent_o
);
  always_comb begin
    hit_vec_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      hit_vec_o[i] = valid_i[i] && (ents_i[i].vpn == key_i);
  end

  // one-hot OR mux, no priority chain
  always_comb begin
    ent_o = '0;
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) begin
        ent_o = ent_o | ents_i[i];
        idx_o = idx_o | IDX_W'(i);
      end
    end
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/xlat_tlb_victim.sv
`timescale 1ns/1ps
module xlat_tlb_victim #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign idx_o = free_any ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && !free_any) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xlat_tlb_store.sv
`timescale 1ns/1ps
module xlat_tlb_store
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic    [IDX_W-1:0]   wr_idx_i,
  input  xl_ent_t               wr_ent_i,
  input  logic                  flush_proc_i,
  output xl_ent_t [ENTRIES-1:0] ents_o,
  output logic    [ENTRIES-1:0] valid_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        ents_o[g]  <= '0;
      end else begin
        if (flush_proc_i && !ents_o[g].glb) valid_o[g] <= 1'b0;
        // fill written after flush
        if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
          valid_o[g] <= 1'b1;
          ents_o[g]  <= wr_ent_i;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [FLAG_W-1:0] lk_flags_o,
  output logic              lk_global_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [FLAG_W-1:0] fill_flags_i,
  input  logic              fill_global_i,
  input  logic              flush_proc_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  xl_ent_t [ENTRIES-1:0] ents;
  logic    [ENTRIES-1:0] ent_valid;
  logic    [ENTRIES-1:0] ent_glb;
  logic    [ENTRIES-1:0] lk_hit_vec;
  logic    [ENTRIES-1:0] fl_hit_vec;
  logic                  lk_any, fl_any;
  logic    [IDX_W-1:0]   lk_idx, fl_idx, vic_idx, wr_idx;
  xl_ent_t               lk_ent, fl_ent, wr_ent;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glb
    assign ent_glb[g] = ents[g].glb;
  end

  xlat_tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_cam (
    .ents_i(ents), .valid_i(ent_valid), .key_i(lk_vpn_i),
    .hit_vec_o(lk_hit_vec), .hit_o(lk_any), .idx_o(lk_idx), .ent_o(lk_ent)
  );

  // second compare port: refill of a resident page reuses its slot
  xlat_tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_fl_cam (
    .ents_i(ents), .valid_i(ent_valid), .key_i(fill_vpn_i),
    .hit_vec_o(fl_hit_vec), .hit_o(fl_any), .idx_o(fl_idx), .ent_o(fl_ent)
  );

  xlat_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(ent_valid),
    .alloc_i(fill_en_i && !fl_any), .idx_o(vic_idx)
  );

  assign wr_idx = fl_any ? fl_idx : vic_idx;
  assign wr_ent = '{vpn: fill_vpn_i, ppn: fill_ppn_i, flags: fill_flags_i, glb: fill_global_i};

  xlat_tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(fill_en_i), .wr_idx_i(wr_idx),
    .wr_ent_i(wr_ent), .flush_proc_i(flush_proc_i),
    .ents_o(ents), .valid_o(ent_valid)
  );

  assign lk_hit_o    = lk_valid_i && lk_any;
  assign lk_miss_o   = lk_valid_i && !lk_any;
  assign lk_ppn_o    = lk_hit_o ? lk_ent.ppn   : '0;
  assign lk_flags_o  = lk_hit_o ? lk_ent.flags : '0;
  assign lk_global_o = lk_hit_o && lk_ent.glb;
  assign lk_paddr_o  = lk_hit_o ? {lk_ent.ppn, lk_off_i} : '0;

  logic unused_ok;
  assign unused_ok = ^{lk_idx, fl_ent};
endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [VPN_W-1:0]   lk_vpn_i,
  input logic [OFF_W-1:0]   lk_off_i,
  input logic               lk_hit_o,
  input logic               lk_miss_o,
  input logic [PPN_W-1:0]   lk_ppn_o,
  input logic [PA_W-1:0]    lk_paddr_o,
  input logic               fill_en_i,
  input logic [VPN_W-1:0]   fill_vpn_i,
  input logic [PPN_W-1:0]   fill_ppn_i,
  input logic               flush_proc_i,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_glb
);
  a_r4_onehot_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec));

  a_r2_fill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (!lk_valid_i || lk_vpn_i != $past(fill_vpn_i) ||
                   (lk_hit_o && lk_ppn_o == $past(fill_ppn_i))));

  a_r3_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  a_r5_flush_proc_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !fill_en_i) |=> ((ent_valid & ~ent_glb) == '0));

  a_r5_flush_keeps_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !fill_en_i) |=> ((ent_valid & ent_glb) == $past(ent_valid & ent_glb)));

  a_r4_no_loss_without_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_proc_i |=> $countones(ent_valid) >= $past($countones(ent_valid)));

  a_r8_paddr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFF_W-1:0] == lk_off_i && lk_paddr_o[PA_W-1:OFF_W] == lk_ppn_o));
endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i),
  .lk_off_i(lk_off_i), .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_ppn_o(lk_ppn_o),
  .lk_paddr_o(lk_paddr_o), .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
  .fill_ppn_i(fill_ppn_i), .flush_proc_i(flush_proc_i), .lk_hit_vec(lk_hit_vec),
  .ent_valid(ent_valid), .ent_glb(ent_glb)
);

// File: tb/xlat_tlb_bench.sv
`timescale 1ns/1ps
module xlat_tlb_bench;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [29:0] lk_vpn = '0;
  logic [12:0] lk_off = '0;
  logic        lk_hit, lk_miss, lk_global;
  logic [20:0] lk_ppn;
  logic [3:0]  lk_flags;
  logic [33:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [29:0] fill_vpn = '0;
  logic [20:0] fill_ppn = '0;
  logic [3:0]  fill_flags = '0;
  logic        fill_global = 1'b0;
  logic        flush_proc = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  xlat_tlb #(.ENTRIES(N)) u_xlat_tlb (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn),
    .lk_off_i(lk_off), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_ppn_o(lk_ppn),
    .lk_flags_o(lk_flags), .lk_global_o(lk_global), .lk_paddr_o(lk_paddr),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_flags_i(fill_flags), .fill_global_i(fill_global), .flush_proc_i(flush_proc)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fill_en = 1'b0; flush_proc = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(logic [29:0] v, logic [20:0] p, logic [3:0] f, logic g);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_flags = f; fill_global = g;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_proc = 1'b1;
    @(negedge clk);
    flush_proc = 1'b0;
  endtask

  // lookup expecting a hit with the given contents
  task automatic look_hit(string req, logic [29:0] v, logic [12:0] o,
                          logic [20:0] p, logic [3:0] f, logic g);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_off = o;
    #1;
    chk(req, lk_hit, 1'b1);
    chk(req, lk_ppn, p);
    chk("R9", lk_flags, f);
    chk("R9", lk_global, g);
    chk("R8", lk_paddr, {p, o});
  endtask

  task automatic look_miss(string req, logic [29:0] v);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_off = 13'h1abc;
    #1;
    chk(req, lk_hit, 1'b0);
    chk("R3", lk_miss, 1'b1);
    chk("R3", {lk_ppn, lk_flags, lk_global, lk_paddr}, '0);
  endtask

  task automatic t_reset();
    do_reset();
    look_miss("R1", 30'h0);
    look_miss("R1", 30'h3fff_ffff);
    look_miss("R1", 30'h155);
  endtask

  task automatic t_basic();
    do_reset();
    fill(30'h0000_0010, 21'h0_0abc, 4'b0011, 1'b0);
    fill(30'h3fff_fffe, 21'h1f_ffff, 4'b0101, 1'b1);
    fill(30'h2000_0000, 21'h00_0001, 4'b1000, 1'b0);
    look_hit("R2", 30'h0000_0010, 13'h0000, 21'h0_0abc, 4'b0011, 1'b0);
    look_hit("R2", 30'h3fff_fffe, 13'h1fff, 21'h1f_ffff, 4'b0101, 1'b1);
    look_hit("R2", 30'h2000_0000, 13'h0a5a, 21'h00_0001, 4'b1000, 1'b0);
    look_miss("R3", 30'h0000_0011);
    // no request: neither hit nor miss even for a resident page
    @(negedge clk);
    lk_valid = 1'b0; lk_vpn = 30'h0000_0010;
    #1;
    chk("R3", {lk_hit, lk_miss}, 2'b00);
    chk("R3", lk_ppn, 21'h0);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 30'h777; fill_ppn = 21'h123; fill_flags = 4'h1; fill_global = 1'b0;
    lk_valid = 1'b1; lk_vpn = 30'h777;
    #1;
    chk("R2 same-cycle", lk_hit, 1'b0);
    @(negedge clk);
    fill_en = 1'b0;
    #1;
    chk("R2 next-cycle", lk_hit, 1'b1);
    chk("R2 next-cycle", lk_ppn, 21'h123);
  endtask

  task automatic t_flush();
    do_reset();
    fill(30'h100, 21'h1, 4'h1, 1'b1);
    fill(30'h101, 21'h2, 4'h2, 1'b0);
    fill(30'h102, 21'h3, 4'h4, 1'b1);
    fill(30'h103, 21'h4, 4'h8, 1'b0);
    flush();
    look_hit("R5 global kept", 30'h100, 13'h10, 21'h1, 4'h1, 1'b1);
    look_miss("R5 proc gone", 30'h101);
    look_hit("R5 global kept", 30'h102, 13'h20, 21'h3, 4'h4, 1'b1);
    look_miss("R5 proc gone", 30'h103);
  endtask

  task automatic t_flush_fill();
    do_reset();
    fill(30'h40, 21'h40, 4'h3, 1'b0);
    @(negedge clk);
    flush_proc = 1'b1;
    fill_en = 1'b1; fill_vpn = 30'h41; fill_ppn = 21'h41; fill_flags = 4'h7; fill_global = 1'b0;
    @(negedge clk);
    flush_proc = 1'b0; fill_en = 1'b0;
    look_miss("R6 old proc", 30'h40);
    look_hit("R6 new fill", 30'h41, 13'h5, 21'h41, 4'h7, 1'b0);
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < N; i++) fill(30'(1000 + i), 21'(2000 + i), 4'h1, 1'b0);
    for (int i = 0; i < N; i++) look_hit("R7 full", 30'(1000 + i), 13'h0, 21'(2000 + i), 4'h1, 1'b0);
    // refill resident page: overwritten in place, nothing evicted
    fill(30'(1005), 21'h1a_bcde, 4'h6, 1'b0);
    look_hit("R4 refill", 30'(1005), 13'h3, 21'h1a_bcde, 4'h6, 1'b0);
    look_hit("R4 no evict", 30'(1000), 13'h0, 21'(2000), 4'h1, 1'b0);
    // new pages evict in round-robin order starting at 0
    fill(30'h5000, 21'h5000, 4'h2, 1'b0);
    look_miss("R7 evict 0", 30'(1000));
    look_hit("R7 keep 1", 30'(1001), 13'h0, 21'(2001), 4'h1, 1'b0);
    fill(30'h5001, 21'h5001, 4'h2, 1'b0);
    look_miss("R7 evict 1", 30'(1001));
    look_hit("R7 new", 30'h5000, 13'h0, 21'h5000, 4'h2, 1'b0);
    look_hit("R7 new", 30'h5001, 13'h0, 21'h5001, 4'h2, 1'b0);
    // free slot taken before pointer: make one global, flush, refill
    fill(30'(1010), 21'h77, 4'h1, 1'b1);
    flush();
    fill(30'h6000, 21'h6000, 4'h1, 1'b0);
    look_hit("R7 free slot", 30'(1010), 13'h0, 21'h77, 4'h1, 1'b1);
    look_hit("R7 free slot", 30'h6000, 13'h0, 21'h6000, 4'h1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_timing();
    t_flush();
    t_flush_fill();
    t_replace();
    finish_run();
  end
endmodule